// File: doc/BRIEF.md
# SMBus Target Completion Status Classifier

This block watches one SMBus target transaction at a time while the local target logic is servicing it. It then gives a 4-bit completion code at the moment the transaction ends. A bit-level front end supplies decoded events: start, repeated start, stop, a strobe at each byte boundary, a level that is high while a byte is only partly shifted, the acknowledge the target intends to drive, and the acknowledge level sampled on the bus. Two timeout detectors report clock-low and data-low conditions. A CRC engine reports whether the received PEC matched its own.

Two write-only transaction kinds are classified. The first is a counted block write, with an expected data-byte count and a separate receive limit. The second is a notification with a fixed payload of three data bytes. The first byte strobe after a start is the address byte, and it is never counted as data. Violations found at byte boundaries are held in sticky flags. The final code is chosen by a fixed priority in the cycle the transaction ends. It is registered together with a one-cycle `done` pulse.

Top module: `smb_tgt_status`

## Requirements
- R1: After reset, `status` is 0000 and both `done` and `busy` are 0. `done` is high for exactly the one cycle after the ending event, and `status` changes only in that cycle. `status` holds its value between endings. A stop from the busy state returns `busy` to 0.
- R2: A clock-low timeout while busy ends the transaction with 0101. A data-low timeout ends it with 0110. If both arrive together, clock-low wins.
- R3: A stop, start or repeated start while `mid_byte` is high ends the transaction with protocol error 0010.
- R4: At a byte strobe, `nack_drive`=1 together with `ack_sampled`=0 is a collision, and the transaction reports 0010.
- R5: For a block write (`txn_type`=0), a stop after fewer data bytes than `exp_count` gives 0010. Receiving more data bytes than `exp_count` also gives 0010. Exactly `exp_count` bytes, including the full-scale value, is not an error.
- R6: A start or repeated start on a byte boundary, arriving after the target drove NACK on the previous byte, gives 0010.
- R7: A block-write data byte whose 1-based index exceeds `rx_limit` gives hardware NACK 0011. Once this has happened, a stop before `exp_count` bytes is not counted as a protocol error.
- R8: For a block write with `pec_en`=1 and `pec_match`=0 at the ending event, the code is 0001. `pec_match` has no effect when `pec_en`=0.
- R9: For a notification (`txn_type`=1), exactly 3 data bytes gives 0000. Fewer or more gives 0010. The PEC inputs have no effect.
- R10: When several conditions hold together, the priority is timeout, then protocol error, then hardware NACK, then PEC error, then success.
- R11: The code 0100 is never produced. A start or repeated start on a boundary with no preceding target NACK ends the current transaction as a stop would, and a new transaction begins at once with `busy` held at 1.
- R12: While `busy` is 0, stop, byte strobes and timeouts produce no `done` and leave `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start condition pulse |
| ev_rstart | input | 1 | Repeated start condition pulse |
| ev_stop | input | 1 | Stop condition pulse |
| byte_done | input | 1 | Byte boundary strobe (end of acknowledge slot) |
| mid_byte | input | 1 | High while a byte is partly shifted |
| nack_drive | input | 1 | Target intends NACK for this byte (valid with byte_done) |
| ack_sampled | input | 1 | Sampled acknowledge level, 1 = NACK (valid with byte_done) |
| txn_type | input | 1 | Kind of transaction, sampled at start: 0 block write, 1 notification |
| exp_count | input | CW | Expected block-write data bytes |
| rx_limit | input | CW | Receive-byte limit before hardware NACK |
| pec_en | input | 1 | Transaction uses PEC |
| pec_match | input | 1 | Received PEC equals computed PEC |
| to_clk_low | input | 1 | Clock-low timeout pulse |
| to_data_low | input | 1 | Data-low timeout pulse |
| busy | output | 1 | A transaction is being tracked |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Latched completion code |

## Verification
The bench builds the block with `CW`=4, so `exp_count` and `rx_limit` top out at 15. This makes the saturation edge of the data counter reachable in a few dozen cycles: fifteen bytes must pass cleanly against an expected count of 15, and a sixteenth must still be seen as an overrun. The small width also keeps the limit-versus-count interaction close at hand. A limit of 2 against an expected count of 5 shows that the hardware-NACK code replaces a short-count protocol error.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

  typedef enum logic [3:0] {
    STS_OK       = 4'h0,
    STS_PEC      = 4'h1,
    STS_PROTO    = 4'h2,
    STS_HW_NACK  = 4'h3,
    STS_EXT_NACK = 4'h4,
    STS_TO_CLK   = 4'h5,
    STS_TO_DATA  = 4'h6
  } sts_e;

  typedef enum logic {
    TT_BLKWR   = 1'b0,
    TT_HNOTIFY = 1'b1
  } ttype_e;

  localparam int unsigned HN_DATA_BYTES = 3;

  typedef struct packed {
    logic to_clk;
    logic to_data;
    logic proto;
    logic hw_nack;
    logic pec_bad;
  } verdict_t;

endpackage

// File: rtl/smb_tgt_track.sv
module smb_tgt_track
  import smb_tgt_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          begin_txn,
  input  logic          end_txn,
  input  logic          byte_evt,
  input  logic          txn_type_in,
  input  logic          nack_drive,
  output logic          busy,
  output ttype_e        ttype,
  output logic          addr_seen,
  output logic [CW-1:0] data_cnt,
  output logic          nack_prev
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic          busy_n, addr_n, nack_n, upd;
  ttype_e        ttype_n;
  logic [CW-1:0] cnt_n;

  assign upd = begin_txn | end_txn | byte_evt;

  always_comb begin
    busy_n  = busy;
    ttype_n = ttype;
    addr_n  = addr_seen;
    cnt_n   = data_cnt;
    nack_n  = nack_prev;
    if (byte_evt) begin
      if (!addr_seen) begin
        addr_n = 1'b1;
      end else if (data_cnt != CNT_MAX) begin
        cnt_n = data_cnt + 1'b1;
      end
      nack_n = nack_drive;
    end
    if (end_txn) begin
      busy_n = 1'b0;
    end
    if (begin_txn) begin
      busy_n  = 1'b1;
      ttype_n = ttype_e'(txn_type_in);
      addr_n  = 1'b0;
      cnt_n   = '0;
      nack_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      ttype     <= TT_BLKWR;
      addr_seen <= 1'b0;
      data_cnt  <= '0;
      nack_prev <= 1'b0;
    end else if (upd) begin
      busy      <= busy_n;
      ttype     <= ttype_n;
      addr_seen <= addr_n;
      data_cnt  <= cnt_n;
      nack_prev <= nack_n;
    end
  end

endmodule

// File: rtl/smb_tgt_viol.sv
module smb_tgt_viol
  import smb_tgt_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          byte_evt,
  input  ttype_e        ttype,
  input  logic          addr_seen,
  input  logic [CW-1:0] data_cnt,
  input  logic          nack_prev,
  input  logic          nack_drive,
  input  logic          ack_sampled,
  input  logic [CW-1:0] exp_count,
  input  logic [CW-1:0] rx_limit,
  input  logic          rs_evt,
  input  logic          mid_byte,
  input  logic          pec_en,
  input  logic          pec_match,
  output logic          proto_o,
  output logic          hwn_o,
  output logic          pec_o
);

  localparam logic [CW:0] HN_W = (CW+1)'(HN_DATA_BYTES);

  logic        is_hn, data_byte, coll, over_exp, over_lim, short_cnt;
  logic        proto_q, hwn_q, proto_n, hwn_n, upd;
  logic [CW:0] cnt_new, cnt_cur;

  assign is_hn     = (ttype == TT_HNOTIFY);
  assign cnt_cur   = {1'b0, data_cnt};
  assign cnt_new   = cnt_cur + 1'b1;
  assign data_byte = byte_evt & addr_seen;
  assign coll      = byte_evt & nack_drive & ~ack_sampled;
  assign over_exp  = data_byte & (is_hn ? (cnt_new > HN_W)
                                        : (cnt_new > {1'b0, exp_count}));
  assign over_lim  = data_byte & ~is_hn & (cnt_new > {1'b0, rx_limit});

  // Short transfer, judged at the ending event
  assign short_cnt = ~addr_seen |
                     (is_hn ? (cnt_cur < HN_W)
                            : ((cnt_cur < {1'b0, exp_count}) & ~hwn_q));

  assign upd = clr | byte_evt;

  always_comb begin
    proto_n = proto_q | coll | over_exp;
    hwn_n   = hwn_q | over_lim;
    if (clr) begin
      proto_n = 1'b0;
      hwn_n   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      proto_q <= 1'b0;
      hwn_q   <= 1'b0;
    end else if (upd) begin
      proto_q <= proto_n;
      hwn_q   <= hwn_n;
    end
  end

  assign proto_o = proto_q | mid_byte | (rs_evt & nack_prev) | short_cnt;
  assign hwn_o   = hwn_q;
  assign pec_o   = ~is_hn & pec_en & ~pec_match;

endmodule

// File: rtl/smb_tgt_sel.sv
module smb_tgt_sel
  import smb_tgt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     end_txn,
  input  verdict_t vd,
  output logic     done,
  output sts_e     status
);

  sts_e sts_n;

  always_comb begin
    if (vd.to_clk)       sts_n = STS_TO_CLK;
    else if (vd.to_data) sts_n = STS_TO_DATA;
    else if (vd.proto)   sts_n = STS_PROTO;
    else if (vd.hw_nack) sts_n = STS_HW_NACK;
    else if (vd.pec_bad) sts_n = STS_PEC;
    else                 sts_n = STS_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= end_txn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= STS_OK;
    end else if (end_txn) begin
      status <= sts_n;
    end
  end

endmodule

// File: rtl/smb_tgt_status.sv
module smb_tgt_status
  import smb_tgt_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_rstart,
  input  logic          ev_stop,
  input  logic          byte_done,
  input  logic          mid_byte,
  input  logic          nack_drive,
  input  logic          ack_sampled,
  input  logic          txn_type,
  input  logic [CW-1:0] exp_count,
  input  logic [CW-1:0] rx_limit,
  input  logic          pec_en,
  input  logic          pec_match,
  input  logic          to_clk_low,
  input  logic          to_data_low,
  output logic          busy,
  output logic          done,
  output logic [3:0]    status
);

  logic          rs_evt, to_any, end_txn, begin_txn, byte_evt, clr;
  logic          addr_seen, nack_prev;
  logic          proto, hwn, pec_bad;
  logic [CW-1:0] data_cnt;
  ttype_e        ttype;
  verdict_t      vd;
  sts_e          sts;

  assign rs_evt    = ev_start | ev_rstart;
  assign to_any    = to_clk_low | to_data_low;
  assign end_txn   = busy & (ev_stop | rs_evt | to_any);
  assign begin_txn = rs_evt & ~(busy & to_any);
  assign byte_evt  = byte_done & busy & ~end_txn;
  assign clr       = begin_txn | end_txn;

  smb_tgt_track #(.CW(CW)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .begin_txn   (begin_txn),
    .end_txn     (end_txn),
    .byte_evt    (byte_evt),
    .txn_type_in (txn_type),
    .nack_drive  (nack_drive),
    .busy        (busy),
    .ttype       (ttype),
    .addr_seen   (addr_seen),
    .data_cnt    (data_cnt),
    .nack_prev   (nack_prev)
  );

  smb_tgt_viol #(.CW(CW)) u_viol (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .byte_evt    (byte_evt),
    .ttype       (ttype),
    .addr_seen   (addr_seen),
    .data_cnt    (data_cnt),
    .nack_prev   (nack_prev),
    .nack_drive  (nack_drive),
    .ack_sampled (ack_sampled),
    .exp_count   (exp_count),
    .rx_limit    (rx_limit),
    .rs_evt      (rs_evt),
    .mid_byte    (mid_byte),
    .pec_en      (pec_en),
    .pec_match   (pec_match),
    .proto_o     (proto),
    .hwn_o       (hwn),
    .pec_o       (pec_bad)
  );

  assign vd = '{to_clk: to_clk_low, to_data: to_data_low,
                proto: proto, hw_nack: hwn, pec_bad: pec_bad};

  smb_tgt_sel u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .end_txn (end_txn),
    .vd      (vd),
    .done    (done),
    .status  (sts)
  );

  assign status = sts;

endmodule

// File: rtl/smb_tgt_status_chk.sv
module smb_tgt_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_start,
  input logic       ev_rstart,
  input logic       ev_stop,
  input logic       mid_byte,
  input logic       to_clk_low,
  input logic       to_data_low,
  input logic       busy,
  input logic       done,
  input logic [3:0] status
);

  AST_TO_CLK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && to_clk_low |=> done && status == 4'h5); // R2

  AST_TO_DATA_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !to_clk_low && to_data_low |=> done && status == 4'h6); // R2

  AST_MID_BYTE_PROTO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !to_clk_low && !to_data_low && mid_byte &&
    (ev_stop || ev_start || ev_rstart) |=> done && status == 4'h2); // R3

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(status)); // R1

  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status != 4'h4 && status <= 4'h6); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ev_start && !ev_rstart |=> !done); // R12

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ev_stop && !ev_start && !ev_rstart |=> !busy); // R1

endmodule

bind smb_tgt_status smb_tgt_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_start    (ev_start),
  .ev_rstart   (ev_rstart),
  .ev_stop     (ev_stop),
  .mid_byte    (mid_byte),
  .to_clk_low  (to_clk_low),
  .to_data_low (to_data_low),
  .busy        (busy),
  .done        (done),
  .status      (status)
);

// File: tb/tb_smb_tgt_status.sv
module tb_smb_tgt_status;

  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_start, ev_rstart, ev_stop, byte_done, mid_byte;
  logic          nack_drive, ack_sampled, txn_type, pec_en, pec_match;
  logic          to_clk_low, to_data_low;
  logic [CW-1:0] exp_count, rx_limit;
  logic          busy, done;
  logic [3:0]    status;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] last_sts;

  always #4 clk = ~clk;

  smb_tgt_status #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_rstart(ev_rstart),
    .ev_stop(ev_stop), .byte_done(byte_done), .mid_byte(mid_byte),
    .nack_drive(nack_drive), .ack_sampled(ack_sampled), .txn_type(txn_type),
    .exp_count(exp_count), .rx_limit(rx_limit), .pec_en(pec_en),
    .pec_match(pec_match), .to_clk_low(to_clk_low), .to_data_low(to_data_low),
    .busy(busy), .done(done), .status(status)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_start(input bit hn);
    @(negedge clk); txn_type = hn; ev_start = 1'b1;
    @(negedge clk); ev_start = 1'b0;
  endtask

  task automatic do_byte(input bit nd, input bit as);
    @(negedge clk); byte_done = 1'b1; nack_drive = nd; ack_sampled = as;
    @(negedge clk); byte_done = 1'b0; nack_drive = 1'b0; ack_sampled = 1'b0;
  endtask

  // start, address byte, then n clean data bytes
  task automatic txn(input bit hn, input int n);
    do_start(hn);
    do_byte(1'b0, 1'b0);
    for (int i = 0; i < n; i++) do_byte(1'b0, 1'b0);
  endtask

  // kind: 0 stop, 1 restart, 2 clock-low, 3 data-low, 4 both timeouts
  task automatic finish(input int kind, input bit mid, input logic [3:0] exp,
                        input string tag);
    @(negedge clk);
    mid_byte = mid;
    case (kind)
      0: ev_stop = 1'b1;
      1: ev_rstart = 1'b1;
      2: to_clk_low = 1'b1;
      3: to_data_low = 1'b1;
      default: begin to_clk_low = 1'b1; to_data_low = 1'b1; end
    endcase
    @(negedge clk);
    ev_stop = 1'b0; ev_rstart = 1'b0; to_clk_low = 1'b0; to_data_low = 1'b0;
    mid_byte = 1'b0;
    check({3'b0, done}, 4'h1, {tag, " done"});
    check(status, exp, {tag, " status"});
    last_sts = exp;
    @(negedge clk);
    check({3'b0, done}, 4'h0, {tag, " done drop"});
  endtask

  task automatic t_reset;
    check(status, 4'h0, "R1 reset status");
    check({3'b0, done}, 4'h0, "R1 reset done");
    check({3'b0, busy}, 4'h0, "R1 reset busy");
  endtask

  task automatic t_blockwrite;
    exp_count = 4'd3; rx_limit = 4'd8; pec_en = 1'b1; pec_match = 1'b1;
    txn(1'b0, 3); finish(0, 1'b0, 4'h0, "R1 clean write");
    check({3'b0, busy}, 4'h0, "R1 idle after stop");
    pec_match = 1'b0;
    txn(1'b0, 3); finish(0, 1'b0, 4'h1, "R8 pec mismatch");
    pec_en = 1'b0;
    txn(1'b0, 3); finish(0, 1'b0, 4'h0, "R8 pec disabled");
    pec_en = 1'b1; pec_match = 1'b1;
    exp_count = 4'd15; rx_limit = 4'd15;
    txn(1'b0, 15); finish(0, 1'b0, 4'h0, "R5 full-scale count");
    txn(1'b0, 16); finish(0, 1'b0, 4'h2, "R5 overrun past full scale");
  endtask

  task automatic t_count_errors;
    exp_count = 4'd3; rx_limit = 4'd8;
    txn(1'b0, 2); finish(0, 1'b0, 4'h2, "R5 short stop");
    txn(1'b0, 4); finish(0, 1'b0, 4'h2, "R5 extra byte");
    do_start(1'b0);
    do_byte(1'b0, 1'b0); do_byte(1'b1, 1'b0); do_byte(1'b0, 1'b0); do_byte(1'b0, 1'b0);
    finish(0, 1'b0, 4'h2, "R4 collision");
    txn(1'b0, 1); finish(0, 1'b1, 4'h2, "R3 stop mid byte");
    txn(1'b0, 3); finish(1, 1'b1, 4'h2, "R3 restart mid byte");
    finish(2, 1'b0, 4'h5, "R2 timeout after restart");
  endtask

  task automatic t_limit;
    exp_count = 4'd5; rx_limit = 4'd2; pec_en = 1'b1; pec_match = 1'b1;
    txn(1'b0, 2); do_byte(1'b1, 1'b1);
    finish(0, 1'b0, 4'h3, "R7 limit nack");
    pec_match = 1'b0;
    txn(1'b0, 2); do_byte(1'b1, 1'b1);
    finish(0, 1'b0, 4'h3, "R10 hw nack over pec");
    pec_match = 1'b1;
    txn(1'b0, 2); do_byte(1'b1, 1'b1);
    finish(1, 1'b0, 4'h2, "R6 restart after nack");
    check({3'b0, busy}, 4'h1, "R11 busy after restart");
    finish(3, 1'b0, 4'h6, "R2 data-low timeout");
  endtask

  task automatic t_notify;
    exp_count = 4'd2; rx_limit = 4'd8; pec_en = 1'b1; pec_match = 1'b1;
    txn(1'b0, 2);
    txn_type = 1'b1;
    finish(1, 1'b0, 4'h0, "R11 restart completes write");
    check({3'b0, busy}, 4'h1, "R11 busy held");
    do_byte(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) do_byte(1'b0, 1'b0);
    finish(0, 1'b0, 4'h0, "R9 notify after restart");
    pec_match = 1'b0;
    txn(1'b1, 3); finish(0, 1'b0, 4'h0, "R9 notify ignores pec");
    txn(1'b1, 2); finish(0, 1'b0, 4'h2, "R9 notify short");
    txn(1'b1, 4); finish(0, 1'b0, 4'h2, "R9 notify long");
    do_start(1'b1); do_byte(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) do_byte(1'b0, 1'b1);
    finish(0, 1'b0, 4'h0, "R11 master nack not 0100");
    pec_match = 1'b1;
  endtask

  task automatic t_timeouts;
    exp_count = 4'd3; rx_limit = 4'd8;
    txn(1'b0, 1); finish(2, 1'b1, 4'h5, "R2 clock-low");
    txn(1'b0, 1); finish(3, 1'b0, 4'h6, "R2 data-low");
    txn(1'b0, 1); finish(4, 1'b0, 4'h5, "R2 both timeouts");
    txn(1'b0, 5); finish(3, 1'b0, 4'h6, "R10 timeout over protocol");
  endtask

  task automatic t_idle;
    @(negedge clk); ev_stop = 1'b1;
    @(negedge clk); ev_stop = 1'b0;
    check({3'b0, done}, 4'h0, "R12 idle stop");
    do_byte(1'b1, 1'b0);
    check({3'b0, done}, 4'h0, "R12 idle byte");
    @(negedge clk); to_clk_low = 1'b1; to_data_low = 1'b1;
    @(negedge clk); to_clk_low = 1'b0; to_data_low = 1'b0;
    check({3'b0, done}, 4'h0, "R12 idle timeout");
    check(status, last_sts, "R12 status unchanged");
    check({3'b0, busy}, 4'h0, "R12 still idle");
  endtask

  initial begin
    rst_n = 1'b0;
    ev_start = 1'b0; ev_rstart = 1'b0; ev_stop = 1'b0; byte_done = 1'b0;
    mid_byte = 1'b0; nack_drive = 1'b0; ack_sampled = 1'b0; txn_type = 1'b0;
    pec_en = 1'b0; pec_match = 1'b1; to_clk_low = 1'b0; to_data_low = 1'b0;
    exp_count = '0; rx_limit = '0; last_sts = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blockwrite();
    t_count_errors();
    t_limit();
    t_notify();
    t_timeouts();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule